// File: doc/BRIEF.md
# Dual-Reload PWM Timer

This block drives a power stage switch with a pulse-width modulated signal. It does not compare a free-running counter against a threshold. Instead, one down-counter holds the remaining length of the current output level. When that count runs out, the output changes level and the counter is reloaded with the duration that belongs to the new level. An 8-bit command word is mapped onto a high duration and a low duration. The two always add up to a fixed period of `PERIOD` clock ticks, so the switching frequency never moves. For example, 20000 ticks at a 100 MHz clock gives 5 kHz.

A control loop outside the block presents a new command and pulses the update strobe. The strobe copies the derived durations into shadow storage. That storage is promoted to the active durations only at the start of the next period, so a period is never made from a mix of old and new values. A period always begins with its high part. When the high duration is zero, the period is low throughout. When the low duration is zero, the period is high throughout. Neither case produces a short pulse.

The phase timer is a two-state machine. `PH_LOW` drives the output low and `PH_HIGH` drives it high. The transitions are named as follows:
- **low expiry, rise**: leaves `PH_LOW` for `PH_HIGH` when the next period has a nonzero high time.
- **low expiry, hold low**: stays in `PH_LOW` with a full-period reload when the next high time is zero.
- **high expiry, fall**: goes from `PH_HIGH` to `PH_LOW` with the low time.
- **high expiry, hold high**: stays in `PH_HIGH` when the low time is zero and the next period is not all-low.
- **high expiry, drop to zero duty**: goes from `PH_HIGH` to `PH_LOW` for a full period when the low time is zero and the next high time is zero.

A period boundary is the expiry at the end of `PH_LOW`, or an expiry in `PH_HIGH` when the low time is zero.

Top module: `dual_reload_pwm`

## Requirements
- R1: While reset is asserted the output is low. After release, the output stays low for exactly `PERIOD` cycles, because reset loads the low duration of an all-low setting.
- R2: The output changes level only when the timer expires. Each level lasts exactly the number of cycles loaded for it, and every period is exactly `PERIOD` cycles long, high part first.
- R3: For a captured command c below `CMD_FULL`, the high time is floor(c * `PERIOD` / `CMD_FULL`) cycles and the low time is `PERIOD` minus the high time.
- R4: A command of `CMD_FULL` or more saturates the high time to `PERIOD`, so the output is high for the whole period.
- R5: The command bus is sampled only in a cycle where the update strobe is high. Changing the command without a strobe has no effect on the output.
- R6: Values captured during a period take effect at the next period boundary. A strobe sampled on the boundary edge itself applies one period later. With several strobes in one period, the last one wins.
- R7: A zero high time gives a period that is low throughout. A zero low time gives a period that is high throughout. Changes between these two extremes switch exactly once, at the boundary, with no glitch pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 8 | Duty command, sampled on the update strobe |
| upd | input | 1 | Update strobe, one cycle per request |
| pwm_out | output | 1 | Modulated output |

## Verification
The assertions assume two things about the inputs:
- After release, reset stays deasserted.
- The command is held steady in every cycle in which the update strobe is high.

The saturation check assumes that `CMD_FULL` fits in the command width. The stimulus drives the command and the strobe only at falling clock edges and changes the command together with the strobe. It sweeps every command code, including the saturated codes, through single strobes at a fixed point inside a period. It then adds a command change without a strobe, two strobes in one period, and a strobe timed on the boundary edge itself.

// File: rtl/pwm_types_pkg.sv
package pwm_types_pkg;

    // Output level held by the phase timer
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

endpackage

// File: rtl/pwm_duty_map.sv
// Maps a command word onto high and low durations that sum to PERIOD.
module pwm_duty_map #(
    parameter int PERIOD   = 20000,
    parameter int CMD_W    = 8,
    parameter int CMD_FULL = 250
) (
    input  logic [CMD_W-1:0]                 cmd,
    output logic [$clog2(PERIOD+1)-1:0]      on_ticks,
    output logic [$clog2(PERIOD+1)-1:0]      off_ticks
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam int PW = CMD_W + CW;
    localparam logic [CW-1:0]    PERIOD_C = CW'(PERIOD);
    localparam logic [PW-1:0]    PERIOD_W = PW'(PERIOD);
    localparam logic [CMD_W-1:0] FULL_C   = CMD_W'(CMD_FULL);

    logic [PW-1:0] product;
    logic [PW-1:0] quotient;
    logic          saturate;

    always_comb begin
        product  = PW'(cmd) * PERIOD_W;
        quotient = product / PW'(CMD_FULL);
        saturate = (cmd >= FULL_C) || (quotient > PERIOD_W);
    end

    always_comb begin
        if (saturate) begin
            on_ticks = PERIOD_C;
        end else begin
            on_ticks = quotient[CW-1:0];
        end
        off_ticks = PERIOD_C - on_ticks;
    end

endmodule

// File: rtl/pwm_shadow_regs.sv
// Staging storage written by the update strobe, drained at a period boundary.
module pwm_shadow_regs #(
    parameter int PERIOD = 20000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         upd,
    input  logic                         take,
    input  logic [$clog2(PERIOD+1)-1:0]  new_on,
    input  logic [$clog2(PERIOD+1)-1:0]  new_off,
    output logic [$clog2(PERIOD+1)-1:0]  sh_on,
    output logic [$clog2(PERIOD+1)-1:0]  sh_off,
    output logic                         pend
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW:0] PERIOD_X = (CW + 1)'(PERIOD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_on  <= '0;
            sh_off <= PERIOD_X[CW-1:0];
        end else if (upd) begin
            sh_on  <= new_on;
            sh_off <= new_off;
        end
    end

    // A capture on the boundary edge survives the drain: it is newer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (upd) begin
            pend <= 1'b1;
        end else if (take) begin
            pend <= 1'b0;
        end
    end

    assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(sh_on) && $stable(sh_off)));

    assert_pend_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> pend);

    assert_shadow_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (({1'b0, sh_on} + {1'b0, sh_off}) == PERIOD_X));

endmodule

// File: rtl/pwm_phase_timer.sv
// Two-state phase machine around one reloading down-counter.
module pwm_phase_timer
    import pwm_types_pkg::*;
#(
    parameter int PERIOD = 20000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(PERIOD+1)-1:0]  sh_on,
    input  logic [$clog2(PERIOD+1)-1:0]  sh_off,
    input  logic                         pend,
    output logic                         take,
    output logic                         pwm
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] PERIOD_C = CW'(PERIOD);
    localparam logic [CW-1:0] ONE_C    = CW'(1);

    phase_e        state;
    phase_e        nxt_state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] ld_val;
    logic [CW-1:0] act_on;
    logic [CW-1:0] act_off;
    logic [CW-1:0] eff_on;
    logic [CW-1:0] eff_off;
    logic          expire;
    logic          bound;

    always_comb begin
        expire  = (cnt == ONE_C);
        eff_on  = pend ? sh_on  : act_on;
        eff_off = pend ? sh_off : act_off;
    end

    // Next state and reload value
    always_comb begin
        nxt_state = state;
        ld_val    = cnt - ONE_C;
        bound     = 1'b0;
        unique case (state)
            PH_LOW: begin
                if (expire) begin
                    bound = 1'b1;
                    if (eff_on == '0) begin
                        nxt_state = PH_LOW;      // low expiry, hold low
                        ld_val    = eff_off;
                    end else begin
                        nxt_state = PH_HIGH;     // low expiry, rise
                        ld_val    = eff_on;
                    end
                end
            end
            PH_HIGH: begin
                if (expire) begin
                    if (act_off != '0) begin
                        nxt_state = PH_LOW;      // high expiry, fall
                        ld_val    = act_off;
                    end else begin
                        bound = 1'b1;
                        if (eff_on == '0) begin
                            nxt_state = PH_LOW;  // high expiry, drop to zero duty
                            ld_val    = eff_off;
                        end else begin
                            nxt_state = PH_HIGH; // high expiry, hold high
                            ld_val    = eff_on;
                        end
                    end
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_LOW;
        end else begin
            state <= nxt_state;
        end
    end

    // Counter and active durations
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= PERIOD_C;
            act_on  <= '0;
            act_off <= PERIOD_C;
        end else begin
            cnt <= ld_val;
            if (bound) begin
                act_on  <= eff_on;
                act_off <= eff_off;
            end
        end
    end

    // Outputs
    always_comb begin
        take = bound;
        unique case (state)
            PH_LOW:  pwm = 1'b0;
            PH_HIGH: pwm = 1'b1;
        endcase
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) && (cnt <= PERIOD_C));

    assert_toggle_on_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state) |-> $past(cnt == ONE_C));

    assert_active_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_on) |-> $past(cnt == ONE_C));

    assert_zero_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_on == '0) |-> (state == PH_LOW));

    assert_full_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_off == '0) |-> (state == PH_HIGH));

endmodule

// File: rtl/dual_reload_pwm.sv
// Top: duty mapping, staging and the reloading phase timer.
module dual_reload_pwm #(
    parameter int PERIOD   = 20000,
    parameter int CMD_FULL = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cmd,
    input  logic       upd,
    output logic       pwm_out
);
    localparam int CMD_W = 8;
    localparam int CW    = $clog2(PERIOD + 1);
    localparam logic [CW-1:0]    PERIOD_C = CW'(PERIOD);
    localparam logic [CMD_W-1:0] FULL_C   = CMD_W'(CMD_FULL);

    logic [CW-1:0] map_on;
    logic [CW-1:0] map_off;
    logic [CW-1:0] sh_on;
    logic [CW-1:0] sh_off;
    logic          pend;
    logic          take;

    pwm_duty_map #(
        .PERIOD   (PERIOD),
        .CMD_W    (CMD_W),
        .CMD_FULL (CMD_FULL)
    ) u_map (
        .cmd       (cmd),
        .on_ticks  (map_on),
        .off_ticks (map_off)
    );

    pwm_shadow_regs #(
        .PERIOD (PERIOD)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .take    (take),
        .new_on  (map_on),
        .new_off (map_off),
        .sh_on   (sh_on),
        .sh_off  (sh_off),
        .pend    (pend)
    );

    pwm_phase_timer #(
        .PERIOD (PERIOD)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .sh_on  (sh_on),
        .sh_off (sh_off),
        .pend   (pend),
        .take   (take),
        .pwm    (pwm_out)
    );

    assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (cmd >= FULL_C)) |=> (sh_on == PERIOD_C) && (sh_off == '0));

endmodule

// File: tb/dual_reload_pwm_tb.sv
module dual_reload_pwm_tb;
    localparam int P    = 20;
    localparam int FULL = 250;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd   = 1'b0;
    logic [7:0] cmd   = 8'd0;
    logic       pwm;

    always #2 clk = ~clk;

    dual_reload_pwm #(.PERIOD(P), .CMD_FULL(FULL)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .upd     (upd),
        .pwm_out (pwm)
    );

    int vectors = 0;
    int miss    = 0;
    bit done    = 1'b0;
    int cur_on  = 0;
    bit bpend   = 1'b0;
    int bval    = 0;

    function automatic int on_of(int v);
        if (v >= FULL) return P;
        return (v * P) / FULL;
    endfunction

    task automatic check(logic got, logic exp, string tag);
        vectors++;
        if (got !== exp) begin
            miss++;
            $display("FAIL %s: pwm_out=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // act: 0 none, 1 strobe at offset 3, 2 strobes at 3 and 9,
    //      3 command change without strobe, 4 strobe on the boundary edge
    task automatic run_period(int act, int a, int b, string tag);
        for (int off = 0; off < P; off++) begin
            @(negedge clk);
            check(pwm, (off < cur_on), tag);
            upd = 1'b0;
            case (act)
                1: if (off == 3) begin cmd = 8'(a); upd = 1'b1; end
                2: begin
                    if (off == 3) begin cmd = 8'(a); upd = 1'b1; end
                    if (off == 9) begin cmd = 8'(b); upd = 1'b1; end
                end
                3: if (off == 5) cmd = 8'(a);
                4: if (off == P - 1) begin cmd = 8'(a); upd = 1'b1; end
                default: ;
            endcase
        end
        if (act == 1) begin bpend = 1'b1; bval = a; end
        else if (act == 2) begin bpend = 1'b1; bval = b; end
        if (bpend) begin cur_on = on_of(bval); bpend = 1'b0; end
        if (act == 4) begin bpend = 1'b1; bval = a; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    end

    initial begin
        // R1: reset state and first all-low period
        repeat (3) begin
            @(negedge clk);
            check(pwm, 1'b0, "R1 during reset");
        end
        rst_n = 1'b1;
        for (int n = 1; n < P; n++) begin
            @(negedge clk);
            check(pwm, 1'b0, "R1 first period low");
        end
        run_period(0, 0, 0, "R1 first period low");

        // R2/R3 exhaustive sweep; codes at or above FULL exercise R4
        for (int v = 0; v < 256; v++) begin
            run_period(1, v, 0, (cur_on == P) ? "R4 saturated" : "R2/R3 sweep");
        end
        run_period(0, 0, 0, "R4 saturated");

        // R7: full to zero and back, no glitch
        run_period(1, 255, 0, "R7 extremes");
        run_period(1, 0,   0, "R7 extremes");
        run_period(1, 255, 0, "R7 zero duty");
        run_period(1, 100, 0, "R7 full duty");
        run_period(0, 0,   0, "R7 after full");

        // R5: command change without strobe is ignored
        run_period(3, 7, 0, "R5 ignored");
        run_period(0, 0, 0, "R5 ignored");

        // R6: last strobe wins
        run_period(2, 50, 200, "R6 last wins");
        run_period(0, 0, 0,    "R6 last wins");

        // R6: strobe on the boundary edge applies one period later
        run_period(4, 125, 0, "R6 boundary strobe");
        run_period(0, 0, 0,   "R6 boundary strobe");
        run_period(0, 0, 0,   "R6 boundary strobe applied");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

endmodule